// File: doc/BRIEF.md
# Loop Port Insertion and Bypass Controller

This block decides, for a target port on an arbitrated loop, whether the port is bypassed or participating, and whether it asks the transmitter to send a loop initialization primitive. It watches decoded received primitive sequences (port enable and port bypass, each with a destination address), a received-initialization event, a loop-failure event, the port's static hard address, a loop-attached flag and three configuration bits: wait-for-enable, prevent-bypass and suppress-originated-initialization.

On reset the port is bypassed. Depending on configuration it inserts itself on the first clock after reset, or waits for an enable addressed to it or to the broadcast address. Prevent-bypass makes it ignore all bypass and enable commands and stay participating. Each insertion may produce a single-cycle request for an F7-type initialization. A loop failure always requests the error initialization, and a received initialization is answered while the port participates. The request comes with a 2-bit code selector that the transmitter turns into the actual primitive.

Top module: `loop_port_ins_ctrl`

## Requirements
- R1: While reset is low at a clock edge, after that edge bypass_ctl is 1, participating is 0 and init_req is 0.
- R2: With loop_attached=1, cfg_no_bypass=0 and cfg_wait_enable=0, the port becomes participating at the first clock edge at which reset is high, unless a matching bypass arrives in that cycle.
- R3: With loop_attached=1, cfg_no_bypass=0 and cfg_wait_enable=1, a bypassed port stays bypassed until an enable (enable_valid=1) whose destination equals hard_addr or the broadcast value 8'hFF; it becomes participating at the next edge. Enables to other addresses are ignored.
- R4: With loop_attached=1 and cfg_no_bypass=0, a bypass (bypass_valid=1) whose destination equals hard_addr or 8'hFF makes the port bypassed at the next edge; it wins over an enable in the same cycle. A participating port stays participating otherwise.
- R5: With loop_attached=1 and cfg_no_bypass=1, bypass and enable commands are ignored and the port is participating from the next edge onward.
- R6: An insertion (participating rising while loop_attached=1) with cfg_no_orig_init=0 raises init_req with init_sel=2'b00 for exactly one cycle, at the same edge at which participating rises.
- R7: With cfg_no_orig_init=1 no request accompanies an insertion; a received initialization (init_rcvd=1) while loop_attached=1 and participating gives init_req with init_sel=2'b01 at the next edge, whatever cfg_no_orig_init holds. A received initialization while bypassed is ignored.
- R8: loop_fail=1 with loop_attached=1 gives init_req with init_sel=2'b10 at the next edge, whatever the configuration bits and participation state; loop failure wins over insertion, which wins over response.
- R9: With loop_attached=0 the port is participating from the next edge, bypass_ctl is 0, init_req stays 0, and configuration bits, commands and events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loop_attached | input | 1 | Port sits on an arbitrated loop |
| cfg_wait_enable | input | 1 | Wait for an enable command before inserting |
| cfg_no_bypass | input | 1 | Ignore bypass and enable commands, always participate |
| cfg_no_orig_init | input | 1 | Do not request an initialization on insertion |
| hard_addr | input | 8 | Static hard address of the port |
| enable_valid | input | 1 | Enable primitive sequence received this cycle |
| enable_dest | input | 8 | Destination of the received enable |
| bypass_valid | input | 1 | Bypass primitive sequence received this cycle |
| bypass_dest | input | 8 | Destination of the received bypass |
| init_rcvd | input | 1 | Loop initialization received this cycle |
| loop_fail | input | 1 | Loop failure detected at the input this cycle |
| bypass_ctl | output | 1 | Drives the bypass circuit, 1 = bypassed |
| participating | output | 1 | Port is participating on the loop |
| init_req | output | 1 | One-cycle request to send an initialization primitive |
| init_sel | output | 2 | Code selector: 00 insertion F7, 01 response, 10 loop failure |

## Verification
The assertions assume that enable_valid, bypass_valid, init_rcvd and loop_fail are single-cycle event strobes held only for the cycle they occur in, and that configuration bits and hard_addr change only between cycles. The stimulus draws each event afresh every cycle from $urandom with a fixed seed, picks destinations among the own address, the broadcast value and unrelated values, and changes configuration or asserts reset only occasionally, so that insertion, bypass and response paths are all visited with mixed priorities.

// File: rtl/loop_ins_pkg.sv
// Shared types for the loop port insertion controller.
// Assumes: initialization codes are decoded downstream by the transmitter.
package loop_ins_pkg;
    localparam int ADDR_W_DEFAULT = 8;

    // Code selector sent with an initialization request
    typedef enum logic [1:0] {
        SEL_INSERT  = 2'b00,
        SEL_RESPOND = 2'b01,
        SEL_FAILURE = 2'b10
    } init_sel_e;
endpackage

// File: rtl/lpi_addr_match.sv
// Decides whether a received primitive sequence is meant for this port.
// Assumes: the broadcast destination is the all-ones address.
module lpi_addr_match #(
    parameter int ADDR_W = 8
) (
    input  logic              prim_valid,
    input  logic [ADDR_W-1:0] prim_dest,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              prim_hit
);
    localparam logic [ADDR_W-1:0] BCAST = {ADDR_W{1'b1}};

    // Hit on own address or broadcast
    always_comb begin
        prim_hit = prim_valid && ((prim_dest == own_addr) || (prim_dest == BCAST));
    end
endmodule

// File: rtl/lpi_part_ctrl.sv
// Holds the participation state and derives the bypass control.
// Assumes: hit inputs are single-cycle strobes already address-filtered.
module lpi_part_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_attached,
    input  logic cfg_wait_enable,
    input  logic cfg_no_bypass,
    input  logic enable_hit,
    input  logic bypass_hit,
    output logic part_q,
    output logic inserted,
    output logic bypass_ctl
);
    logic boot_q;
    logic part_d;

    // Next participation decision in priority order
    always_comb begin
        if (!loop_attached)          part_d = 1'b1;
        else if (cfg_no_bypass)      part_d = 1'b1;
        else if (bypass_hit)         part_d = 1'b0;
        else if (enable_hit)         part_d = 1'b1;
        else if (boot_q && !cfg_wait_enable) part_d = 1'b1;
        else                         part_d = part_q;
    end

    // Insertion event: participation rises while on the loop
    always_comb begin
        inserted = loop_attached && part_d && !part_q;
    end

    // State registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part_q <= 1'b0;
            boot_q <= 1'b1;
        end else begin
            part_q <= part_d;
            boot_q <= 1'b0;
        end
    end

    // Bypass circuit follows participation
    always_comb begin
        bypass_ctl = !part_q;
    end

    assert_reset_bypassed_R1: assert property (@(posedge clk)
        !rst_n |=> !part_q);
    assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_attached && !cfg_no_bypass && cfg_wait_enable && !enable_hit && !part_q)
        |=> !part_q);
    assert_bypass_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_attached && !cfg_no_bypass && bypass_hit) |=> !part_q);
    assert_no_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_attached && cfg_no_bypass) |=> part_q);
    assert_detached_part_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_attached |=> part_q);
endmodule

// File: rtl/lpi_init_req.sv
// Generates the one-cycle initialization request and its code selector.
// Assumes: loop_fail and init_rcvd are single-cycle event strobes.
module lpi_init_req
    import loop_ins_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       loop_attached,
    input  logic       cfg_no_orig_init,
    input  logic       inserted,
    input  logic       part_q,
    input  logic       init_rcvd,
    input  logic       loop_fail,
    output logic       init_req,
    output init_sel_e  init_sel
);
    logic      req_d;
    init_sel_e sel_d;

    // Choose request source: failure, then insertion, then response
    always_comb begin
        req_d = 1'b0;
        sel_d = SEL_INSERT;
        if (loop_attached && loop_fail) begin
            req_d = 1'b1;
            sel_d = SEL_FAILURE;
        end else if (inserted && !cfg_no_orig_init) begin
            req_d = 1'b1;
            sel_d = SEL_INSERT;
        end else if (loop_attached && part_q && init_rcvd) begin
            req_d = 1'b1;
            sel_d = SEL_RESPOND;
        end
    end

    // Register the request so it is a clean one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_req <= 1'b0;
            init_sel <= SEL_INSERT;
        end else begin
            init_req <= req_d;
            init_sel <= sel_d;
        end
    end

    assert_reset_noreq_R1: assert property (@(posedge clk)
        !rst_n |=> !init_req);
    assert_insert_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (inserted && !cfg_no_orig_init && !(loop_attached && loop_fail))
        |=> (init_req && init_sel == SEL_INSERT));
    assert_insert_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (init_req && init_sel == SEL_INSERT) |=> !(init_req && init_sel == SEL_INSERT));
    assert_suppress_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_attached && cfg_no_orig_init && !loop_fail && !(part_q && init_rcvd))
        |=> !init_req);
    assert_respond_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_attached && part_q && init_rcvd && !loop_fail)
        |=> (init_req && init_sel == SEL_RESPOND));
    assert_failure_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_attached && loop_fail) |=> (init_req && init_sel == SEL_FAILURE));
    assert_detached_noreq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_attached |=> !init_req);
endmodule

// File: rtl/loop_port_ins_ctrl.sv
// Top: bypass/participation control and initialization requests for a
// target port on an arbitrated loop.
// Assumes: event inputs are one-cycle strobes; configuration is quasi-static.
module loop_port_ins_ctrl
    import loop_ins_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_attached,
    input  logic              cfg_wait_enable,
    input  logic              cfg_no_bypass,
    input  logic              cfg_no_orig_init,
    input  logic [ADDR_W-1:0] hard_addr,
    input  logic              enable_valid,
    input  logic [ADDR_W-1:0] enable_dest,
    input  logic              bypass_valid,
    input  logic [ADDR_W-1:0] bypass_dest,
    input  logic              init_rcvd,
    input  logic              loop_fail,
    output logic              bypass_ctl,
    output logic              participating,
    output logic              init_req,
    output logic [1:0]        init_sel
);
    localparam int N_PRIM = 2;

    logic [N_PRIM-1:0]             prim_valid;
    logic [N_PRIM-1:0][ADDR_W-1:0] prim_dest;
    logic [N_PRIM-1:0]             prim_hit;
    logic                          part_q;
    logic                          inserted;
    init_sel_e                     sel_int;

    // Gather both primitive types for one decoder each
    always_comb begin
        prim_valid = {bypass_valid, enable_valid};
        prim_dest  = {bypass_dest, enable_dest};
    end

    for (genvar g = 0; g < N_PRIM; g++) begin : g_match
        lpi_addr_match #(.ADDR_W(ADDR_W)) u_match (
            .prim_valid (prim_valid[g]),
            .prim_dest  (prim_dest[g]),
            .own_addr   (hard_addr),
            .prim_hit   (prim_hit[g])
        );
    end

    lpi_part_ctrl u_part (
        .clk             (clk),
        .rst_n           (rst_n),
        .loop_attached   (loop_attached),
        .cfg_wait_enable (cfg_wait_enable),
        .cfg_no_bypass   (cfg_no_bypass),
        .enable_hit      (prim_hit[0]),
        .bypass_hit      (prim_hit[1]),
        .part_q          (part_q),
        .inserted        (inserted),
        .bypass_ctl      (bypass_ctl)
    );

    lpi_init_req u_init (
        .clk              (clk),
        .rst_n            (rst_n),
        .loop_attached    (loop_attached),
        .cfg_no_orig_init (cfg_no_orig_init),
        .inserted         (inserted),
        .part_q           (part_q),
        .init_rcvd        (init_rcvd),
        .loop_fail        (loop_fail),
        .init_req         (init_req),
        .init_sel         (sel_int)
    );

    // Expose internal state as plain outputs
    always_comb begin
        participating = part_q;
        init_sel      = sel_int;
    end

    assert_bypass_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_attached && !cfg_no_bypass && bypass_valid &&
         (bypass_dest == hard_addr || bypass_dest == {ADDR_W{1'b1}}))
        |=> (bypass_ctl && !participating));
endmodule

// File: tb/tb_loop_port_ins_ctrl.sv
module tb_loop_port_ins_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam logic [AW-1:0] OWN = 8'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic att = 1'b1, cw = 1'b0, cnb = 1'b0, cno = 1'b0;
    logic [AW-1:0] haddr = OWN;
    logic ev = 1'b0, bv = 1'b0, ir = 1'b0, lf = 1'b0;
    logic [AW-1:0] ed = '0, bd = '0;
    logic bypass_ctl, participating, init_req;
    logic [1:0] init_sel;

    int n_checks = 0, n_errors = 0;
    bit m_part = 1'b0, m_boot = 1'b1, m_req = 1'b0;
    logic [1:0] m_sel = 2'b00;
    string tag_p = "R1", tag_i = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    loop_port_ins_ctrl #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .loop_attached(att), .cfg_wait_enable(cw),
        .cfg_no_bypass(cnb), .cfg_no_orig_init(cno), .hard_addr(haddr),
        .enable_valid(ev), .enable_dest(ed), .bypass_valid(bv), .bypass_dest(bd),
        .init_rcvd(ir), .loop_fail(lf), .bypass_ctl(bypass_ctl),
        .participating(participating), .init_req(init_req), .init_sel(init_sel)
    );

    function automatic bit addr_hit(bit v, logic [AW-1:0] d);
        return v && (d == haddr || d == 8'hFF);
    endfunction

    // Reference model of the requirements, advanced once per edge
    task automatic model_step();
        bit he, hb, np, ins;
        he = addr_hit(ev, ed);
        hb = addr_hit(bv, bd);
        if (!rst_n) begin
            m_part = 0; m_boot = 1; m_req = 0; tag_p = "R1"; tag_i = "R1";
            return;
        end
        if (!att)                begin np = 1; tag_p = "R9"; end
        else if (cnb)            begin np = 1; tag_p = "R5"; end
        else if (hb)             begin np = 0; tag_p = "R4"; end
        else if (he)             begin np = 1; tag_p = "R3"; end
        else if (m_boot && !cw)  begin np = 1; tag_p = "R2"; end
        else                     begin np = m_part; tag_p = cw ? "R3" : "R4"; end
        ins = att && np && !m_part;
        m_req = 0;
        if (!att)                     tag_i = "R9";
        else if (lf)                  begin m_req = 1; m_sel = 2'b10; tag_i = "R8"; end
        else if (ins && !cno)         begin m_req = 1; m_sel = 2'b00; tag_i = "R6"; end
        else if (m_part && ir)        begin m_req = 1; m_sel = 2'b01; tag_i = "R7"; end
        else                          tag_i = ins ? "R7" : "R6";
        m_part = np;
        m_boot = 0;
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: model at the edge, compare just after it, return at negedge
    task automatic cycle();
        @(posedge clk);
        model_step();
        #1;
        chk(tag_p, "participating", int'(participating), int'(m_part));
        chk(tag_p, "bypass_ctl", int'(bypass_ctl), int'(!m_part));
        chk(tag_i, "init_req", int'(init_req), int'(m_req));
        if (m_req) chk(tag_i, "init_sel", int'(init_sel), int'(m_sel));
        @(negedge clk);
        ev = 0; bv = 0; ir = 0; lf = 0;
    endtask

    task automatic do_reset(int n);
        rst_n = 0;
        for (int i = 0; i < n; i++) cycle();
        rst_n = 1;
    endtask

    function automatic logic [AW-1:0] pick_dest();
        int r = int'($urandom_range(0, 3));
        if (r == 0) return haddr;
        if (r == 1) return 8'hFF;
        return 8'(($urandom_range(0, 254) == int'(haddr)) ? 8'h00 : $urandom_range(0, 254));
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        // R1 reset state, R2 self insertion with F7 request (R6)
        do_reset(3);
        cycle(); cycle();
        // R7 response while participating, R4 broadcast bypass
        ir = 1; cycle();
        bv = 1; bd = 8'hFF; cycle(); cycle();
        // R7 received init while bypassed is ignored
        ir = 1; cycle();
        // R3 wait mode: unmatched enable ignored, own address inserts
        cw = 1; do_reset(2); cycle();
        ev = 1; ed = 8'h11; cycle();
        ev = 1; ed = OWN; cycle(); cycle();
        // R4 bypass wins over enable in the same cycle
        ev = 1; ed = 8'hFF; bv = 1; bd = OWN; cycle();
        // R8 failure while bypassed, and over insertion
        lf = 1; cycle();
        ev = 1; ed = OWN; lf = 1; cycle();
        // R7 suppressed insertion request, then response
        cno = 1; bv = 1; bd = OWN; cycle();
        ev = 1; ed = 8'hFF; cycle();
        ir = 1; cycle();
        // R5 prevent bypass ignores commands
        cnb = 1; bv = 1; bd = OWN; cycle(); cycle();
        // R9 detached ignores everything
        cnb = 0; att = 0; bv = 1; bd = 8'hFF; lf = 1; ir = 1; cycle(); cycle();
        att = 1; cno = 0;
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 99) == 0) begin
                cw = 1'($urandom); cnb = ($urandom_range(0, 3) == 0);
                cno = 1'($urandom); att = ($urandom_range(0, 4) != 0);
            end
            if ($urandom_range(0, 149) == 0) rst_n = 0;
            else rst_n = 1;
            ev = ($urandom_range(0, 5) == 0); ed = pick_dest();
            bv = ($urandom_range(0, 7) == 0); bd = pick_dest();
            ir = ($urandom_range(0, 6) == 0);
            lf = ($urandom_range(0, 19) == 0);
            cycle();
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule